// File: doc/BRIEF.md
# Floating-Point Predicate Compare Unit

This unit compares two IEEE-754 operands and turns the result into a single condition bit. The operands are both single precision or both double precision, as chosen by a precision select. The comparison is quiet. It first sorts the pair into one of four relations: less, equal, greater or unordered. A 3-bit predicate code then says which of those relations count as a match.

The condition bit is merged into a copy of the 32-bit floating-point status word supplied by the caller. The unit presents both the merged word and the bare bit. A separate flag reports an invalid operation when a signaling NaN took part in the comparison.

Each comparison is started by a one-cycle strobe. The results are registered on that same clock edge and held until the next strobe. A done pulse marks the cycle in which fresh results appear.

Top module: `fpcmp_unit`

## Requirements
- R1: On the clock edge where `start_i` is high, the results are registered. `done_o` is high for exactly the following cycle and is low at all other times. `cond_o`, `status_o` and `invalid_o` keep their values until the next start.
- R2: The low three bits of the predicate code form a match mask. Bit 0 accepts unordered, bit 1 accepts equal and bit 2 accepts less-than, and greater-than is never accepted. This gives 0 = false, 1 = unordered, 2 = equal, 3 = unordered or equal, 4 = ordered less, 5 = unordered or less, 6 = ordered less-or-equal, 7 = not greater. The condition bit is 1 only if the relation is in the mask.
- R3: Predicate code bits above bit 2 have no effect on any output.
- R4: If either operand is a NaN, the relation is unordered. A NaN has an all-ones exponent and a nonzero fraction. If both NaNs are quiet (top fraction bit 1), `invalid_o` stays 0.
- R5: `invalid_o` is 1 exactly when at least one operand is a signaling NaN, meaning its top fraction bit is 0. The relation is still unordered in that case.
- R6: Positive zero and negative zero compare equal.
- R7: Infinities and subnormals are ordered exactly by sign and magnitude, with no flush to zero.
- R8: The updated status word has the condition bit at bit 29, zeros at bits 31, 30 and 28, and bits 27:0 copied from `status_i`.
- R9: When `dbl_i` is 0, only bits 31:0 of each operand are used, as single precision (8-bit exponent, 23-bit fraction). When `dbl_i` is 1, all 64 bits are used, as double precision (11-bit exponent, 52-bit fraction). The predicate meaning is the same in both formats.
- R10: After reset, `done_o`, `cond_o`, `invalid_o` and `status_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one comparison |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| pred_i | input | 4 | Predicate code; only bits 2:0 are used |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| status_i | input | 32 | Current status/control word |
| done_o | output | 1 | One-cycle result strobe |
| cond_o | output | 1 | Condition bit |
| status_o | output | 32 | Status word with the condition bit merged in |
| invalid_o | output | 1 | Invalid-operation flag (signaling NaN seen) |

## Verification
Every result is due one rising edge after the start strobe: all four outputs change together in the cycle where `done_o` is high. The bench drives the inputs on a falling edge and samples the outputs on the next falling edge, which is half a cycle after the capturing rising edge. To check that results hold, the bench then changes every input with the strobe low. One cycle later it confirms that the outputs are unchanged and that `done_o` has dropped.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
   typedef enum logic [1:0] {
      REL_LT = 2'd0,
      REL_EQ = 2'd1,
      REL_GT = 2'd2,
      REL_UN = 2'd3
   } rel_e;

   localparam int SP_EXP_W  = 8;
   localparam int SP_FRAC_W = 23;
   localparam int DP_EXP_W  = 11;
   localparam int DP_FRAC_W = 52;
   localparam int SP_W      = SP_EXP_W + SP_FRAC_W + 1;
   localparam int DP_W      = DP_EXP_W + DP_FRAC_W + 1;
   localparam int PRED_W    = 3;
endpackage

// File: rtl/fpc_operand.sv
module fpc_operand #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = EXP_W + FRAC_W + 1
) (
   input  logic [W-1:0] val_i,
   output logic         sign_o,
   output logic         nan_o,
   output logic         snan_o,
   output logic         zero_o,
   output logic [W-2:0] mag_o
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign exp_f  = val_i[W-2:FRAC_W];
   assign frac_f = val_i[FRAC_W-1:0];
   assign sign_o = val_i[W-1];
   assign mag_o  = val_i[W-2:0];
   assign nan_o  = (&exp_f) && (|frac_f);
   assign snan_o = nan_o && !frac_f[FRAC_W-1];
   assign zero_o = ~|val_i[W-2:0];
endmodule

// File: rtl/fpc_path.sv
module fpc_path
   import fpcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = EXP_W + FRAC_W + 1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output rel_e         rel_o,
   output logic         snan_o
);
   logic         sa, sb, na, nb, qa, qb, za, zb;
   logic [W-2:0] ma, mb;

   fpc_operand #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_opa (
      .val_i(a_i), .sign_o(sa), .nan_o(na), .snan_o(qa), .zero_o(za), .mag_o(ma));
   fpc_operand #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_opb (
      .val_i(b_i), .sign_o(sb), .nan_o(nb), .snan_o(qb), .zero_o(zb), .mag_o(mb));

   always_comb begin
      if (na || nb)              rel_o = REL_UN;
      else if (za && zb)         rel_o = REL_EQ;
      else if (sa != sb)         rel_o = sa ? REL_LT : REL_GT;
      else if (ma == mb)         rel_o = REL_EQ;
      else if ((ma < mb) ^ sa)   rel_o = REL_LT;
      else                       rel_o = REL_GT;
   end

   assign snan_o = qa || qb;
endmodule

// File: rtl/fpc_predicate.sv
module fpc_predicate
   import fpcmp_pkg::*;
(
   input  logic [PRED_W-1:0] code_i,
   input  rel_e              rel_i,
   output logic              hit_o
);
   always_comb begin
      unique case (rel_i)
         REL_UN:  hit_o = code_i[0];
         REL_EQ:  hit_o = code_i[1];
         REL_LT:  hit_o = code_i[2];
         default: hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
   import fpcmp_pkg::*;
#(
   parameter int OP_W          = 64,
   parameter int STAT_W        = 32,
   parameter int CODE_W        = 4,
   parameter int COND_BIT      = 29,
   parameter bit ENABLE_DOUBLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dbl_i,
   input  logic [CODE_W-1:0] pred_i,
   input  logic [OP_W-1:0]   opa_i,
   input  logic [OP_W-1:0]   opb_i,
   input  logic [STAT_W-1:0] status_i,
   output logic              done_o,
   output logic              cond_o,
   output logic [STAT_W-1:0] status_o,
   output logic              invalid_o
);
   localparam int CLR_LO = COND_BIT - 1;
   localparam int CLR_HI = COND_BIT + 2;

   if (CODE_W < PRED_W) begin : g_chk_code
      $error("CODE_W must be at least %0d", PRED_W);
   end
   if (CLR_LO < 0 || CLR_HI >= STAT_W) begin : g_chk_stat
      $error("COND_BIT leaves no room for the cleared field");
   end
   if (OP_W < (ENABLE_DOUBLE ? DP_W : SP_W)) begin : g_chk_op
      $error("OP_W too narrow for the enabled formats");
   end

   rel_e rel_sp, rel_dp, rel_sel;
   logic inv_sp, inv_dp, inv_sel;
   logic hit;
   logic [STAT_W-1:0] merged;

   fpc_path #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
      .a_i(opa_i[SP_W-1:0]), .b_i(opb_i[SP_W-1:0]), .rel_o(rel_sp), .snan_o(inv_sp));

   if (ENABLE_DOUBLE) begin : g_dp
      fpc_path #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
         .a_i(opa_i[DP_W-1:0]), .b_i(opb_i[DP_W-1:0]), .rel_o(rel_dp), .snan_o(inv_dp));
   end else begin : g_no_dp
      assign rel_dp = rel_sp;
      assign inv_dp = inv_sp;
   end

   assign rel_sel = dbl_i ? rel_dp : rel_sp;
   assign inv_sel = dbl_i ? inv_dp : inv_sp;

   fpc_predicate u_pred (
      .code_i(pred_i[PRED_W-1:0]), .rel_i(rel_sel), .hit_o(hit));

   for (genvar i = 0; i < STAT_W; i++) begin : g_merge
      if (i == COND_BIT) begin : g_cond
         assign merged[i] = hit;
      end else if (i >= CLR_LO && i <= CLR_HI) begin : g_clr
         assign merged[i] = 1'b0;
      end else begin : g_keep
         assign merged[i] = status_i[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         cond_o    <= 1'b0;
         status_o  <= '0;
         invalid_o <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            cond_o    <= hit;
            status_o  <= merged;
            invalid_o <= inv_sel;
         end
      end
   end
endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk #(
   parameter int STAT_W   = 32,
   parameter int CODE_W   = 4,
   parameter int COND_BIT = 29
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [CODE_W-1:0] pred_i,
   input logic [STAT_W-1:0] status_i,
   input logic              done_o,
   input logic              cond_o,
   input logic [STAT_W-1:0] status_o,
   input logic              invalid_o
);
   assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   assert_done_only_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(cond_o) && $stable(status_o) && $stable(invalid_o)));
   assert_false_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && pred_i[2:0] == 3'd0) |=> !cond_o);
   assert_cond_in_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (status_o[COND_BIT] == cond_o));
   assert_cleared_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (status_o[COND_BIT+2] == 1'b0 && status_o[COND_BIT+1] == 1'b0
                  && status_o[COND_BIT-1] == 1'b0));
   assert_low_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (status_o[COND_BIT-2:0] == $past(status_i[COND_BIT-2:0])));
endmodule

bind fpcmp_unit fpcmp_unit_chk #(.STAT_W(STAT_W), .CODE_W(CODE_W), .COND_BIT(COND_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .pred_i(pred_i), .status_i(status_i),
   .done_o(done_o), .cond_o(cond_o), .status_o(status_o), .invalid_o(invalid_o));

// File: tb/fpcmp_unit_tb.sv
`timescale 1ns/1ps
module fpcmp_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        dbl_i = 1'b0;
   logic [3:0]  pred_i = '0;
   logic [63:0] opa_i = '0, opb_i = '0;
   logic [31:0] status_i = '0;
   logic        done_o, cond_o, invalid_o;
   logic [31:0] status_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fpcmp_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i), .pred_i(pred_i),
      .opa_i(opa_i), .opb_i(opb_i), .status_i(status_i), .done_o(done_o),
      .cond_o(cond_o), .status_o(status_o), .invalid_o(invalid_o));

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // relation codes: 0 lt, 1 eq, 2 gt, 3 unordered
   function automatic logic [1:0] ref_rel(bit dbl, logic [63:0] a, logic [63:0] b);
      logic [63:0] ka, kb, sm;
      bit nan_a, nan_b, zer;
      if (dbl) begin
         nan_a = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
         nan_b = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
         zer   = (a[62:0] == 0) && (b[62:0] == 0);
         sm    = 64'h8000_0000_0000_0000;
      end else begin
         a = {32'h0, a[31:0]};
         b = {32'h0, b[31:0]};
         nan_a = (a[30:23] == 8'hFF) && (a[22:0] != 0);
         nan_b = (b[30:23] == 8'hFF) && (b[22:0] != 0);
         zer   = (a[30:0] == 0) && (b[30:0] == 0);
         sm    = 64'h0000_0000_8000_0000;
      end
      if (nan_a || nan_b) return 2'd3;
      if (zer) return 2'd1;
      ka = ((a & sm) != 0) ? (~a & (sm | (sm - 1))) : (a | sm);
      kb = ((b & sm) != 0) ? (~b & (sm | (sm - 1))) : (b | sm);
      if (ka < kb) return 2'd0;
      if (ka == kb) return 2'd1;
      return 2'd2;
   endfunction

   function automatic bit ref_snan(bit dbl, logic [63:0] x);
      if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0) && !x[51];
      return (x[30:23] == 8'hFF) && (x[22:0] != 0) && !x[22];
   endfunction

   function automatic bit ref_cond(logic [3:0] code, logic [1:0] rel);
      bit lt = (rel == 2'd0), eq = (rel == 2'd1), un = (rel == 2'd3);
      case (code[2:0])
         3'd0: return 1'b0;
         3'd1: return un;
         3'd2: return eq;
         3'd3: return un | eq;
         3'd4: return lt;
         3'd5: return un | lt;
         3'd6: return lt | eq;
         default: return rel != 2'd2;
      endcase
   endfunction

   task automatic run_cmp(string req, bit dbl, logic [3:0] code, logic [63:0] a,
                          logic [63:0] b, logic [31:0] st, bit hold_chk);
      bit c, inv;
      logic [31:0] exp_st;
      c      = ref_cond(code, ref_rel(dbl, a, b));
      inv    = ref_snan(dbl, a) || ref_snan(dbl, b);
      exp_st = {2'b00, c, 1'b0, st[27:0]};
      @(negedge clk);
      dbl_i = dbl; pred_i = code; opa_i = a; opb_i = b; status_i = st; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check({req, " done R1"}, done_o, 1);
      check({req, " cond R2"}, cond_o, c);
      check({req, " status R8"}, status_o, exp_st);
      check({req, " invalid R5"}, invalid_o, inv);
      if (hold_chk) begin
         opa_i = ~a; opb_i = ~b; status_i = ~st; pred_i = ~code; dbl_i = ~dbl;
         @(negedge clk);
         check({req, " hold done R1"}, done_o, 0);
         check({req, " hold cond R1"}, cond_o, c);
         check({req, " hold status R1"}, status_o, exp_st);
         check({req, " hold invalid R1"}, invalid_o, inv);
      end
   endtask

   function automatic logic [63:0] pick(bit dbl);
      logic [63:0] v;
      int unsigned r;
      r = $urandom % 8;
      v = {$urandom, $urandom};
      if (dbl) begin
         case (r)
            1: v = {v[63], 63'h0};
            2: v = {v[63], 11'h7FF, 52'h0};
            3: v = {v[63], 11'h7FF, 1'b1, v[50:0]};
            4: v = {v[63], 11'h7FF, 1'b0, v[50:1], 1'b1};
            5: v = {v[63], 11'h0, v[51:0]};
            6: v = {v[63], 11'h3FF, 48'h0, v[3:0]};
            default: ;
         endcase
      end else begin
         case (r)
            1: v[30:0] = '0;
            2: v[30:0] = {8'hFF, 23'h0};
            3: v[30:0] = {8'hFF, 1'b1, v[21:0]};
            4: v[30:0] = {8'hFF, 1'b0, v[21:1], 1'b1};
            5: v[30:23] = 8'h0;
            6: v[30:0] = {8'h7F, 19'h0, v[3:0]};
            default: ;
         endcase
      end
      return v;
   endfunction

   initial begin
      logic [63:0] a, b;
      int unsigned seed;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      check("reset done R10", done_o, 0);
      check("reset cond R10", cond_o, 0);
      check("reset status R10", status_o, 0);
      check("reset invalid R10", invalid_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("idle done R1", done_o, 0);

      // R6: +0 == -0, single and double
      run_cmp("zero sp R6", 0, 4'd2, 64'h0, 64'h8000_0000, 32'h0, 1);
      check("zero sp cond R6", cond_o, 1);
      run_cmp("zero dp R6", 1, 4'd2, 64'h8000_0000_0000_0000, 64'h0, 32'h0, 0);
      check("zero dp cond R6", cond_o, 1);
      // R4: quiet NaN unordered, no invalid
      run_cmp("qnan R4", 0, 4'd1, 64'h7FC0_0000, 64'h3F80_0000, 32'h0, 0);
      check("qnan cond R4", cond_o, 1);
      check("qnan inv R4", invalid_o, 0);
      run_cmp("qnan lt R4", 1, 4'd6, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 32'h0, 0);
      check("qnan le R4", cond_o, 0);
      // R5: signaling NaN
      run_cmp("snan R5", 1, 4'd3, 64'h3FF0_0000_0000_0000, 64'hFFF0_0000_0000_0001, 32'h0, 0);
      check("snan inv R5", invalid_o, 1);
      check("snan cond R5", cond_o, 1);
      // R7: infinity and subnormal ordering
      run_cmp("inf R7", 0, 4'd4, 64'hFF80_0000, 64'h3F80_0000, 32'h0, 0);
      check("neg inf lt R7", cond_o, 1);
      run_cmp("sub R7", 1, 4'd4, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 32'h0, 0);
      check("sub lt R7", cond_o, 1);
      run_cmp("negsub R7", 0, 4'd4, 64'h8000_0002, 64'h8000_0001, 32'h0, 0);
      check("negsub lt R7", cond_o, 1);
      // R3: upper predicate bit ignored (code 8 behaves as 0, 14 as 6)
      run_cmp("hi code R3", 0, 4'd8, 64'h3F80_0000, 64'h3F80_0000, 32'h0, 0);
      check("code8 R3", cond_o, 0);
      run_cmp("hi code6 R3", 0, 4'd14, 64'h3F80_0000, 64'h3F80_0000, 32'h0, 0);
      check("code14 R3", cond_o, 1);
      // R8: status merge
      run_cmp("merge0 R8", 0, 4'd0, 64'h0, 64'h0, 32'hFFFF_FFFF, 0);
      check("merge0 word R8", status_o, 32'h0FFF_FFFF);
      run_cmp("merge1 R8", 0, 4'd7, 64'h0, 64'h0, 32'hFFFF_FFFF, 0);
      check("merge1 word R8", status_o, 32'h2FFF_FFFF);
      // R9: single mode ignores upper operand bits
      run_cmp("sp junk R9", 0, 4'd2, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000, 32'h0, 0);
      check("sp junk eq R9", cond_o, 1);
      run_cmp("dp R9", 1, 4'd2, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000, 32'h0, 0);
      check("dp ne R9", cond_o, 0);

      for (int i = 0; i < 400; i++) begin
         bit dbl;
         dbl = $urandom % 2;
         a = pick(dbl);
         b = (($urandom % 5) == 0) ? a : pick(dbl);
         run_cmp("random R2", dbl, 4'($urandom), a, b, $urandom, (i % 7) == 0);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule